// File: doc/BRIEF.md
# 8-bit PWM Timer with Compare Output

This block is an 8-bit timer/counter with one compare channel and one waveform output. It offers four counting modes: free counting, clear-on-compare, single-slope (fast) PWM and dual-slope (phase-correct) PWM. A shared prescaler sets the count rate. A compare register, buffered in the PWM modes, is matched against the count. A 2-bit action field decides what a match, or the bottom of the count, does to the output. Software can also strobe a forced compare.

Software uses separate write strobes to load the configuration (mode, action, clock select), the compare value and the counter. It can strobe a forced compare and clear the two flags by writing one. The flags are plain outputs so that an interrupt controller outside the block can use them. A reset that is asserted asynchronously passes through a two-stage synchronizer before it is released.

Top module: `pwm8_timer`

## Requirements
- R1: While reset is held, and after it is released, the count, the compare read value, the waveform, the output enable and both flags read zero, and the timer does not count.
- R2: Clock select 000, 110 and 111 stop the counter. Values 001, 010, 011, 100 and 101 advance it once every 1, 8, 64, 256 and 1024 clock cycles.
- R3: In mode 00 (free count) the counter steps 0 to 255 and wraps to 0. The overflow flag is set by the tick taken at 255.
- R4: In mode 10 (clear on compare) the tick taken while the count equals the active compare value returns the count to 0. If the count is already past the compare value, it runs on to 255 and wraps. In modes 00 and 10 a compare write takes effect on the next cycle.
- R5: The compare flag is set by any tick taken while the count equals the active compare value. Writing one to its clear input drops it, but a new setting event in the same cycle takes priority.
- R6: In modes 00 and 10 a match applies action 01 toggle, 10 drive low, 11 drive high, and 00 no change. The output enable is high for a non-zero action in these modes, and only for actions 10 and 11 in the PWM modes.
- R7: In mode 11 (fast PWM) the count wraps at 255, and the overflow flag is set at 255. With action 10 the output goes high on the tick at 255 and low on a match. Action 11 inverts both edges. The event at 255 wins over a match on the same tick.
- R8: In mode 01 (phase-correct) the count runs 0 up to 255, then down to 0, without repeating either end value. The overflow flag is set by the tick taken at 0. With action 10, a match drives the output low while counting up and high while counting down. Action 11 inverts this.
- R9: In modes 01 and 11 a compare write changes the compare read value at once. The value reaches the active comparator only on the tick taken at count 255.
- R10: A force strobe in modes 00 and 10 applies the current action to the output as a match would. It never sets the compare flag and never clears the counter. In modes 01 and 11 it has no effect.
- R11: A counter write overrides any count that cycle. It suppresses a compare match on the next tick.
- R12: The overflow flag clears on a write of one to its clear input, unless an overflow event occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for mode, action and clock select |
| cfg_mode | input | 2 | Mode: 00 free, 01 phase-correct PWM, 10 clear on compare, 11 fast PWM |
| cfg_act | input | 2 | Compare-output action |
| cfg_csel | input | 3 | Clock select |
| force_stb | input | 1 | Forced-compare strobe |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | W | Compare write value |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | W | Counter write value |
| ovf_w1c | input | 1 | Write-one-to-clear for overflow flag |
| cmpf_w1c | input | 1 | Write-one-to-clear for compare flag |
| cnt_o | output | W | Current count |
| cmp_o | output | W | Compare value as last written |
| wave_o | output | 1 | Waveform output |
| wave_oe | output | 1 | Waveform output enable |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare flag |

## Verification
The bench aims at the turning points of the dual-slope count. A design that repeated 255 or 0, or that used the wrong direction at a match, would show a period other than 510 ticks or an inverted output. Compare values 0 and 255 in both PWM modes test the edge priority: getting it wrong gives a glitch instead of a flat or one-tick output. A compare write in mid-period and a compare value lowered below the running count in clear-on-compare test the buffering and the overshoot. Done wrongly, the first changes the duty one period early, and the second clears the counter where it should wrap. Force strobes, a set and a clear in the same cycle, and a counter write onto the compare value each have a wrong outcome that shows at the ports: a raised flag, a cleared count, a lost flag, or a match that should have been suppressed.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

  typedef enum logic [1:0] {
    MD_NORM  = 2'b00,
    MD_PCPWM = 2'b01,
    MD_CTC   = 2'b10,
    MD_FPWM  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ACT_OFF = 2'b00,
    ACT_TGL = 2'b01,
    ACT_CLR = 2'b10,
    ACT_SET = 2'b11
  } act_e;

  // number of prescaler taps reachable from the clock select field
  localparam int NUM_TAPS      = 5;
  localparam int PRE_SHIFT_MAX = 10;

  // log2 of the division ratio for clock select value sel
  function automatic int presc_shift(int sel);
    case (sel)
      1:       return 0;
      2:       return 3;
      3:       return 6;
      4:       return 8;
      default: return PRE_SHIFT_MAX;
    endcase
  endfunction

  // both PWM encodings carry a one in the low bit
  function automatic logic is_pwm(mode_e m);
    return m[0];
  endfunction

endpackage

// File: rtl/pwm8_presc.sv
module pwm8_presc
  import pwm8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] csel,
  output logic       tick
);

  localparam int PW = PRE_SHIFT_MAX;

  logic [PW-1:0]     pre_q;
  logic [PW-1:0]     pre_d;
  logic [NUM_TAPS:0] tap_hit;

  assign tap_hit[0] = 1'b0;

  // one terminal-count detector per division ratio
  for (genvar i = 1; i <= NUM_TAPS; i++) begin : g_tap
    localparam logic [PW-1:0] MASK = PW'((1 << presc_shift(i)) - 1);
    assign tap_hit[i] = ((pre_q & MASK) == MASK);
  end

  always_comb begin
    pre_d = pre_q + 1'b1;
  end

  always_comb begin
    tick = 1'b0;
    for (int k = 1; k <= NUM_TAPS; k++) begin
      if (int'(csel) == k) tick = tap_hit[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

endmodule

// File: rtl/pwm8_count.sv
module pwm8_count
  import pwm8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  mode_e        mode,
  input  logic [W-1:0] cmp_act,
  output logic [W-1:0] cnt_q,
  output logic         dir_up_q,
  output logic         at_max,
  output logic         ovf_hit
);

  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] BOTV = '0;

  logic [W-1:0] cnt_d;
  logic         dir_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_up_q;
    if (mode != MD_PCPWM) dir_d = 1'b1;
    if (wr_en) begin
      cnt_d = wr_data;
    end else if (adv) begin
      case (mode)
        MD_PCPWM: begin
          if (dir_up_q) begin
            if (cnt_q == MAXV) begin
              cnt_d = MAXV - 1'b1;
              dir_d = 1'b0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            if (cnt_q == BOTV) begin
              cnt_d = BOTV + 1'b1;
              dir_d = 1'b1;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        MD_CTC:  cnt_d = (cnt_q == cmp_act) ? BOTV : cnt_q + 1'b1;
        default: cnt_d = cnt_q + 1'b1;
      endcase
    end
  end

  assign at_max  = (cnt_q == MAXV);
  assign ovf_hit = adv & ((mode == MD_PCPWM) ? (cnt_q == BOTV) : (cnt_q == MAXV));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      dir_up_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_d;
      dir_up_q <= dir_d;
    end
  end

endmodule

// File: rtl/pwm8_cmp.sv
module pwm8_cmp
  import pwm8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  mode_e        mode,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_q,
  output logic [W-1:0] cmp_act_q,
  output logic [W-1:0] cmp_buf_q,
  output logic         match
);

  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] act_d;
  logic [W-1:0] buf_d;
  logic         blk_q;
  logic         blk_d;

  always_comb begin
    buf_d = wr_en ? wr_data : cmp_buf_q;
    act_d = cmp_act_q;
    if (!is_pwm(mode)) begin
      if (wr_en) act_d = wr_data;
    end else if (adv && (cnt_q == MAXV)) begin
      act_d = cmp_buf_q;
    end
    blk_d = blk_q;
    if (cnt_wr)   blk_d = 1'b1;
    else if (adv) blk_d = 1'b0;
  end

  assign match = adv & ~blk_q & (cnt_q == cmp_act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_act_q <= '0;
      cmp_buf_q <= '0;
      blk_q     <= 1'b0;
    end else begin
      cmp_act_q <= act_d;
      cmp_buf_q <= buf_d;
      blk_q     <= blk_d;
    end
  end

endmodule

// File: rtl/pwm8_outwave.sv
module pwm8_outwave
  import pwm8_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  mode_e mode,
  input  act_e  act,
  input  logic  match,
  input  logic  force_stb,
  input  logic  dir_up,
  input  logic  at_max,
  output logic  wave_q,
  output logic  oe
);

  logic wave_d;

  always_comb begin
    wave_d = wave_q;
    if (!is_pwm(mode)) begin
      if (match || force_stb) begin
        case (act)
          ACT_TGL: wave_d = ~wave_q;
          ACT_CLR: wave_d = 1'b0;
          ACT_SET: wave_d = 1'b1;
          default: wave_d = wave_q;
        endcase
      end
    end else if (act[1]) begin
      if (mode == MD_FPWM) begin
        if (adv && at_max) wave_d = (act == ACT_CLR);
        else if (match)    wave_d = (act == ACT_SET);
      end else if (match) begin
        wave_d = dir_up ? (act == ACT_SET) : (act == ACT_CLR);
      end
    end
  end

  assign oe = is_pwm(mode) ? act[1] : (act != ACT_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

endmodule

// File: rtl/pwm8_timer.sv
module pwm8_timer
  import pwm8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_mode,
  input  logic [1:0]   cfg_act,
  input  logic [2:0]   cfg_csel,
  input  logic         force_stb,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         ovf_w1c,
  input  logic         cmpf_w1c,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cmp_o,
  output logic         wave_o,
  output logic         wave_oe,
  output logic         ovf_flag,
  output logic         cmp_flag
);

  // reset synchronizer: asserts at once, releases on the second edge
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // configuration
  mode_e      mode_q, mode_d;
  act_e       act_q, act_d;
  logic [2:0] csel_q, csel_d;

  always_comb begin
    mode_d = mode_q;
    act_d  = act_q;
    csel_d = csel_q;
    if (cfg_we) begin
      mode_d = mode_e'(cfg_mode);
      act_d  = act_e'(cfg_act);
      csel_d = cfg_csel;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= MD_NORM;
      act_q  <= ACT_OFF;
      csel_q <= 3'b000;
    end else begin
      mode_q <= mode_d;
      act_q  <= act_d;
      csel_q <= csel_d;
    end
  end

  // datapath
  logic         tick;
  logic         adv;
  logic         dir_up;
  logic         at_max;
  logic         ovf_set;
  logic         match;
  logic [W-1:0] cmp_act;

  assign adv = tick & ~cnt_we;

  pwm8_presc u_presc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .csel  (csel_q),
    .tick  (tick)
  );

  pwm8_count #(.W(W)) u_count (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .adv      (adv),
    .wr_en    (cnt_we),
    .wr_data  (cnt_wdata),
    .mode     (mode_q),
    .cmp_act  (cmp_act),
    .cnt_q    (cnt_o),
    .dir_up_q (dir_up),
    .at_max   (at_max),
    .ovf_hit  (ovf_set)
  );

  pwm8_cmp #(.W(W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .adv       (adv),
    .mode      (mode_q),
    .wr_en     (cmp_we),
    .wr_data   (cmp_wdata),
    .cnt_wr    (cnt_we),
    .cnt_q     (cnt_o),
    .cmp_act_q (cmp_act),
    .cmp_buf_q (cmp_o),
    .match     (match)
  );

  pwm8_outwave u_wave (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .adv       (adv),
    .mode      (mode_q),
    .act       (act_q),
    .match     (match),
    .force_stb (force_stb),
    .dir_up    (dir_up),
    .at_max    (at_max),
    .wave_q    (wave_o),
    .oe        (wave_oe)
  );

  // flags: a setting event wins over a clear in the same cycle
  logic ovf_d;
  logic cmpf_d;

  always_comb begin
    ovf_d  = ovf_set | (ovf_flag & ~ovf_w1c);
    cmpf_d = match   | (cmp_flag & ~cmpf_w1c);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      ovf_flag <= ovf_d;
      cmp_flag <= cmpf_d;
    end
  end

endmodule

// File: rtl/pwm8_timer_chk.sv
module pwm8_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode_q,
  input logic [1:0]   act_q,
  input logic [2:0]   csel_q,
  input logic         adv,
  input logic         match,
  input logic         ovf_set,
  input logic [W-1:0] cmp_act,
  input logic         cnt_we,
  input logic         force_stb,
  input logic         ovf_w1c,
  input logic [W-1:0] cnt_o,
  input logic         wave_o,
  input logic         wave_oe,
  input logic         ovf_flag,
  input logic         cmp_flag
);

  localparam logic [W-1:0] MAXV = '1;

  assert_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csel_q == 3'b000 && !cnt_we) |=> $stable(cnt_o));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00 && adv && cnt_o == MAXV) |=> (cnt_o == '0 && ovf_flag));

  assert_ctc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b10 && adv && cnt_o == cmp_act) |=> (cnt_o == '0));

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> cmp_flag);

  assert_oe_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q == 2'b00) |-> !wave_oe);

  assert_fast_bottom_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b11 && act_q == 2'b10 && adv && cnt_o == MAXV) |=> wave_o);

  assert_pc_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && adv && cnt_o == MAXV) |=> (cnt_o == MAXV - 1'b1));

  assert_pc_bottom_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && adv && cnt_o == '0) |=> ovf_flag);

  assert_buffer_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[0] && !(adv && cnt_o == MAXV)) |=> $stable(cmp_act));

  assert_force_noflag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (force_stb && !match && !cmp_flag) |=> !cmp_flag);

  assert_force_pwm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (force_stb && mode_q[0] && !adv) |=> $stable(wave_o));

  assert_write_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> !match);

  assert_ovf_priority_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set && ovf_w1c) |=> ovf_flag);

endmodule

bind pwm8_timer pwm8_timer_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .mode_q    (mode_q),
  .act_q     (act_q),
  .csel_q    (csel_q),
  .adv       (adv),
  .match     (match),
  .ovf_set   (ovf_set),
  .cmp_act   (cmp_act),
  .cnt_we    (cnt_we),
  .force_stb (force_stb),
  .ovf_w1c   (ovf_w1c),
  .cnt_o     (cnt_o),
  .wave_o    (wave_o),
  .wave_oe   (wave_oe),
  .ovf_flag  (ovf_flag),
  .cmp_flag  (cmp_flag)
);

// File: tb/pwm8_timer_tb_top.sv
module pwm8_timer_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_mode;
  logic [1:0] cfg_act;
  logic [2:0] cfg_csel;
  logic       force_stb;
  logic       cmp_we;
  logic [7:0] cmp_wdata;
  logic       cnt_we;
  logic [7:0] cnt_wdata;
  logic       ovf_w1c;
  logic       cmpf_w1c;
  logic [7:0] cnt_o;
  logic [7:0] cmp_o;
  logic       wave_o;
  logic       wave_oe;
  logic       ovf_flag;
  logic       cmp_flag;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string tag   = "R1";

  // reference state
  logic [7:0] m_cnt, m_buf, m_cmp;
  logic       m_up, m_wave, m_ovf, m_cmpf, m_blk;
  logic [1:0] m_mode, m_act;
  logic [2:0] m_csel;

  pwm8_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_mode  (cfg_mode),
    .cfg_act   (cfg_act),
    .cfg_csel  (cfg_csel),
    .force_stb (force_stb),
    .cmp_we    (cmp_we),
    .cmp_wdata (cmp_wdata),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .ovf_w1c   (ovf_w1c),
    .cmpf_w1c  (cmpf_w1c),
    .cnt_o     (cnt_o),
    .cmp_o     (cmp_o),
    .wave_o    (wave_o),
    .wave_oe   (wave_oe),
    .ovf_flag  (ovf_flag),
    .cmp_flag  (cmp_flag)
  );

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 8'd0; m_buf = 8'd0; m_cmp = 8'd0;
    m_up = 1'b1; m_wave = 1'b0; m_ovf = 1'b0; m_cmpf = 1'b0; m_blk = 1'b0;
    m_mode = 2'b00; m_act = 2'b00; m_csel = 3'b000;
  endtask

  // expected next state, from the requirement text (only csel 0,1,6,7 here)
  task automatic model_edge();
    logic tk, mt, pwm, nu, nw, nblk, ovs;
    logic [7:0] nc, nb, na;
    pwm = m_mode[0];
    tk  = (m_csel == 3'd1) && !cnt_we;
    mt  = tk && !m_blk && (m_cnt == m_cmp);
    nc  = m_cnt;
    nu  = (m_mode == 2'b01) ? m_up : 1'b1;
    if (cnt_we) nc = cnt_wdata;
    else if (tk) begin
      if (m_mode == 2'b01) begin
        if (m_up) begin
          if (m_cnt == 8'd255) begin nc = 8'd254; nu = 1'b0; end
          else nc = m_cnt + 8'd1;
        end else begin
          if (m_cnt == 8'd0) begin nc = 8'd1; nu = 1'b1; end
          else nc = m_cnt - 8'd1;
        end
      end else if (m_mode == 2'b10) nc = (m_cnt == m_cmp) ? 8'd0 : m_cnt + 8'd1;
      else nc = m_cnt + 8'd1;
    end
    ovs = tk && ((m_mode == 2'b01) ? (m_cnt == 8'd0) : (m_cnt == 8'd255));
    nw = m_wave;
    if (!pwm) begin
      if (mt || force_stb) begin
        if (m_act == 2'd1) nw = !m_wave;
        else if (m_act == 2'd2) nw = 1'b0;
        else if (m_act == 2'd3) nw = 1'b1;
      end
    end else if (m_act[1]) begin
      if (m_mode == 2'b11) begin
        if (tk && m_cnt == 8'd255) nw = (m_act == 2'd2);
        else if (mt) nw = (m_act == 2'd3);
      end else if (mt) nw = m_up ? (m_act == 2'd3) : (m_act == 2'd2);
    end
    nb = cmp_we ? cmp_wdata : m_buf;
    na = m_cmp;
    if (!pwm) begin
      if (cmp_we) na = cmp_wdata;
    end else if (tk && m_cnt == 8'd255) na = m_buf;
    nblk = cnt_we ? 1'b1 : (tk ? 1'b0 : m_blk);
    m_ovf  = ovs | (m_ovf & !ovf_w1c);
    m_cmpf = mt  | (m_cmpf & !cmpf_w1c);
    m_cnt = nc; m_up = nu; m_wave = nw; m_buf = nb; m_cmp = na; m_blk = nblk;
    if (cfg_we) begin m_mode = cfg_mode; m_act = cfg_act; m_csel = cfg_csel; end
  endtask

  task automatic cyc();
    logic exp_oe;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    n_vec++;
    exp_oe = m_mode[0] ? m_act[1] : (m_act != 2'b00);
    chk("count",    cnt_o,    m_cnt);
    chk("cmp_read", cmp_o,    m_buf);
    chk("wave",     wave_o,   m_wave);
    chk("wave_oe",  wave_oe,  exp_oe);
    chk("ovf_flag", ovf_flag, m_ovf);
    chk("cmp_flag", cmp_flag, m_cmpf);
    cfg_we = 1'b0; force_stb = 1'b0; cmp_we = 1'b0;
    cnt_we = 1'b0; ovf_w1c = 1'b0; cmpf_w1c = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) cyc();
  endtask

  task automatic run_to(input logic [7:0] v);
    for (int i = 0; i < 2000 && m_cnt != v; i++) cyc();
  endtask

  task automatic cfg(input logic [1:0] md, input logic [1:0] ac, input logic [2:0] cs);
    cfg_mode = md; cfg_act = ac; cfg_csel = cs; cfg_we = 1'b1;
    cyc();
  endtask

  task automatic wcmp(input logic [7:0] v);
    cmp_wdata = v; cmp_we = 1'b1;
    cyc();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_mode = 2'b00; cfg_act = 2'b00; cfg_csel = 3'b000;
    force_stb = 1'b0; cmp_we = 1'b0; cmp_wdata = 8'd0; cnt_we = 1'b0; cnt_wdata = 8'd0;
    ovf_w1c = 1'b0; cmpf_w1c = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: values while reset is held
    tag = "R1";
    n_vec++;
    chk("count", cnt_o, 0); chk("cmp_read", cmp_o, 0); chk("wave", wave_o, 0);
    chk("wave_oe", wave_oe, 0); chk("ovf_flag", ovf_flag, 0); chk("cmp_flag", cmp_flag, 0);
    rst_n = 1'b1;
    run(4);

    // R2: stopped selections
    tag = "R2";
    cfg(2'b00, 2'b00, 3'b000);
    cnt_wdata = 8'd5; cnt_we = 1'b1; cyc();
    run(20);
    cfg(2'b00, 2'b00, 3'b110); run(20);
    cfg(2'b00, 2'b00, 3'b111); run(20);

    // R3: free count wraps and raises overflow
    tag = "R3";
    cfg(2'b00, 2'b00, 3'b001);
    run(600);

    // R12: set beats clear, then a plain clear
    tag = "R12";
    run_to(8'd255);
    ovf_w1c = 1'b1; cyc();
    run(3);
    ovf_w1c = 1'b1; cyc();
    run(5);

    // R6: actions on match in clear-on-compare
    tag = "R6";
    cmp_wdata = 8'd20; cmp_we = 1'b1;
    cfg(2'b10, 2'b01, 3'b001); run(100);
    cfg(2'b10, 2'b10, 3'b001); run(50);
    cfg(2'b10, 2'b11, 3'b001); run(50);
    cfg(2'b10, 2'b00, 3'b001); run(30);
    cfg(2'b00, 2'b01, 3'b001); wcmp(8'd100); run(600);

    // R4: top from compare value and overshoot after lowering it
    tag = "R4";
    cfg(2'b10, 2'b01, 3'b001);
    wcmp(8'd40); run(100);
    run_to(8'd30); wcmp(8'd10); run(300);

    // R5: compare flag clear, set priority
    tag = "R5";
    cfg(2'b00, 2'b01, 3'b001); wcmp(8'd77);
    run_to(8'd77); cmpf_w1c = 1'b1; cyc();
    run(3); cmpf_w1c = 1'b1; cyc(); run(5);

    // R11: counter write onto the compare value
    tag = "R11";
    cfg(2'b10, 2'b01, 3'b001); wcmp(8'd50);
    cmpf_w1c = 1'b1; cyc();
    run_to(8'd45);
    cnt_wdata = 8'd50; cnt_we = 1'b1; cyc();
    run(300);

    // R10: force strobes
    tag = "R10";
    cmpf_w1c = 1'b1; cfg(2'b00, 2'b01, 3'b000);
    force_stb = 1'b1; cyc(); run(2);
    force_stb = 1'b1; cyc(); run(2);
    cfg(2'b10, 2'b11, 3'b001); wcmp(8'd100);
    run_to(8'd60); force_stb = 1'b1; cyc();
    cfg(2'b10, 2'b10, 3'b001); force_stb = 1'b1; cyc();
    run_to(8'd100); run(5);
    cfg(2'b11, 2'b10, 3'b001); run(10);
    force_stb = 1'b1; cyc(); run(300);
    cfg(2'b01, 2'b11, 3'b001); run(20);
    force_stb = 1'b1; cyc(); run(50);

    // R7: fast PWM with edge compare values
    tag = "R7";
    cfg(2'b11, 2'b10, 3'b001);
    wcmp(8'd128); run(600);
    wcmp(8'd0);   run(600);
    wcmp(8'd255); run(600);
    wcmp(8'd3);   run(600);
    cfg(2'b11, 2'b11, 3'b001); wcmp(8'd128); run(600);

    // R9: mid-period compare writes in both PWM modes
    tag = "R9";
    cfg(2'b11, 2'b10, 3'b001); wcmp(8'd50); run(300);
    run_to(8'd100); wcmp(8'd200); run(400);
    cfg(2'b01, 2'b10, 3'b001); run(600);
    run_to(8'd150); wcmp(8'd20); run(700);

    // R8: phase-correct counting and direction-dependent actions
    tag = "R8";
    cfg(2'b01, 2'b10, 3'b001);
    wcmp(8'd100); run(1100);
    wcmp(8'd0);   run(1100);
    wcmp(8'd255); run(1100);
    cfg(2'b01, 2'b11, 3'b001); wcmp(8'd100); run(1100);

    // R2: prescaled tick spacing, measured at the count output
    tag = "R2";
    for (int s = 2; s <= 5; s++) begin
      int d;
      int gap;
      logic [7:0] prev;
      d = (s == 2) ? 8 : (s == 3) ? 64 : (s == 4) ? 256 : 1024;
      cfg_mode = 2'b00; cfg_act = 2'b00; cfg_csel = 3'(s); cfg_we = 1'b1;
      @(negedge clk); cfg_we = 1'b0;
      @(negedge clk);
      prev = cnt_o;
      for (int i = 0; i < 2 * d && cnt_o == prev; i++) @(negedge clk);
      prev = cnt_o;
      gap = 0;
      for (int i = 0; i < 2 * d && cnt_o == prev; i++) begin
        @(negedge clk);
        gap++;
      end
      n_vec++;
      chk("tick_gap", gap, d);
    end

    summary();
  end

endmodule